// File: doc/BRIEF.md
# Ranged Translation Cache Purge Engine

This block is a small fully associative translation cache, plus the engine that empties it on a global purge command. Each entry holds a valid bit, a 3-bit region tag, a virtual address and a page size. The page size is stored as a power-of-two exponent. A purge request carries two 64-bit operands. The first gives the region tag and the virtual address. The second gives the size of the purge window as an exponent. The engine walks the entries one per clock and removes every entry in the same region whose page touches the window in any way.

A request from a less privileged level, a request made with virtualization mode set, or a request with an unsupported window size is refused with a one-cycle fault pulse, and nothing is changed. An accepted request emits a one-cycle outbound notice. The notice carries the region, address and exponent, and a flag saying whether the purge comes from a page remapping. Completion waits on an input that reports that earlier data accesses have drained. This gives the purge release ordering. A simple insert port fills the cache, and a lookup port reports whether an address hits.

Top module: `tlb_range_purge`

## Requirements
- R1: The region tag of a purge is `pg_addr[63:61]` and its address is `pg_addr[60:0]`; only entries whose tag equals that region can be removed.
- R2: The purge window exponent is `pg_size[7:2]`; the window is 2^exp bytes, starting at the address aligned down to that size (low address bits are ignored).
- R3: Every valid entry whose page, aligned down to its own size, overlaps the window is invalidated, whether the page lies inside the window, the window lies inside the page, or they are equal.
- R4: Entries that do not overlap the window, or that carry another region tag, remain valid after the purge.
- R5: A request with `cpl` not equal to 0 (0 = most privileged) or with `vm`=1 raises `fault` for exactly one cycle, starting the cycle after the request. It sends no notice and changes no entry.
- R6: A request whose window exponent is below 12 or above 60 faults in the same way as R5.
- R7: Only one purge is in flight. A request made while `busy`=1 is ignored and has no effect on the entries.
- R8: In the cycle after an accepted request, `bc_vld` pulses for one cycle with `bc_remap`, `bc_rid`, `bc_va` and `bc_exp` equal to the request's remap flag, region tag, address and exponent, and `busy` rises.
- R9: `done` pulses for one cycle only after the scan has ended and `drained` was high; `busy` is low in that cycle. While `drained` stays low, the engine stays busy.
- R10: The insert port writes an entry only when idle and only when its exponent is between 12 and 28; otherwise the write is ignored. `lk_hit` is 1 when a valid entry with tag `lk_rid` covers `lk_va`.
- R11: Reset invalidates all entries and clears `busy`, `done`, `fault` and `bc_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en | input | 1 | Insert strobe |
| ins_idx | input | 3 | Entry slot to write |
| ins_rid | input | 3 | Region tag of new entry |
| ins_va | input | 61 | Virtual address of new entry |
| ins_exp | input | 6 | Page size exponent of new entry |
| lk_rid | input | 3 | Lookup region tag |
| lk_va | input | 61 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| pg_req | input | 1 | Purge request strobe |
| pg_addr | input | 64 | Region tag and purge address operand |
| pg_size | input | 64 | Purge size operand, exponent in bits 7:2 |
| pg_remap | input | 1 | Purge caused by page remapping |
| cpl | input | 2 | Current privilege level, 0 most privileged |
| vm | input | 1 | Virtualization mode bit |
| drained | input | 1 | Earlier data accesses are visible |
| busy | output | 1 | Purge in flight |
| done | output | 1 | Purge complete pulse |
| fault | output | 1 | Refused request pulse |
| bc_vld | output | 1 | Outbound purge notice pulse |
| bc_remap | output | 1 | Notice flags a remapping purge |
| bc_rid | output | 3 | Notice region tag |
| bc_va | output | 61 | Notice address |
| bc_exp | output | 6 | Notice window exponent |

## Verification
The bench targets overlap in both directions. One case is a large page with a small window inside it. A compare that only checked whether the page fell inside the window would leave that stale translation in place. Other cases are unaligned purge addresses, which an engine that skipped alignment would miss; the same address in a different region, which a design that ignored the tag would wrongly wipe; and the top of the address space. It also sends requests that are illegal by privilege, mode or size, sends a second request while busy, and holds back the drained input. A design that got these wrong would corrupt the cache, overlap purges, or signal completion before earlier accesses were visible.

// File: rtl/tlb_range_purge.sv
module tlb_range_purge #(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 61,
  parameter int RID_W     = 3,
  parameter int EXP_W     = 6,
  parameter int MIN_EXP   = 12,
  parameter int MAX_PGEXP = 28,
  parameter int MAX_PUEXP = 60,
  parameter int IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [RID_W-1:0] ins_rid,
  input  logic [VA_W-1:0]  ins_va,
  input  logic [EXP_W-1:0] ins_exp,
  input  logic [RID_W-1:0] lk_rid,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  input  logic             pg_req,
  input  logic [63:0]      pg_addr,
  input  logic [63:0]      pg_size,
  input  logic             pg_remap,
  input  logic [1:0]       cpl,
  input  logic             vm,
  input  logic             drained,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic             bc_vld,
  output logic             bc_remap,
  output logic [RID_W-1:0] bc_rid,
  output logic [VA_W-1:0]  bc_va,
  output logic [EXP_W-1:0] bc_exp
);
  localparam logic [EXP_W-1:0] EMIN   = EXP_W'(MIN_EXP);
  localparam logic [EXP_W-1:0] EPGMAX = EXP_W'(MAX_PGEXP);
  localparam logic [EXP_W-1:0] EPUMAX = EXP_W'(MAX_PUEXP);
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(ENTRIES - 1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WAIT} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [ENTRIES-1:0] v;
  logic [RID_W-1:0] e_rid [ENTRIES];
  logic [VA_W-1:0]  e_va  [ENTRIES];
  logic [EXP_W-1:0] e_exp [ENTRIES];

  wire [RID_W-1:0] rq_rid = pg_addr[63 -: RID_W];
  wire [VA_W-1:0]  rq_va  = pg_addr[VA_W-1:0];
  wire [EXP_W-1:0] rq_exp = pg_size[7:2];
  wire unused_ok = &{1'b0, pg_size[63:8], pg_size[1:0]};

  wire rq_bad = (cpl != 2'd0) | vm | (rq_exp < EMIN) | (rq_exp > EPUMAX);
  wire idle   = (st == S_IDLE);
  wire ins_ok = ins_en & idle & ~pg_req & (ins_exp >= EMIN) & (ins_exp <= EPGMAX);

  assign busy = ~idle;

  wire [EXP_W-1:0] m_exp    = (e_exp[idx] > bc_exp) ? e_exp[idx] : bc_exp;
  wire [VA_W-1:0]  scan_dif = e_va[idx] ^ bc_va;
  wire hit_scan = v[idx] & (e_rid[idx] == bc_rid) & ((scan_dif >> m_exp) == '0);

  logic [ENTRIES-1:0] lhit;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_lk
    assign lhit[i] = v[i] & (e_rid[i] == lk_rid) & (((e_va[i] ^ lk_va) >> e_exp[i]) == '0);
  end
  assign lk_hit = |lhit;

  always_ff @(posedge clk) begin
    if (ins_ok) begin
      e_rid[ins_idx] <= ins_rid;
      e_va[ins_idx]  <= ins_va;
      e_exp[ins_idx] <= ins_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      v        <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
      bc_vld   <= 1'b0;
      bc_remap <= 1'b0;
      bc_rid   <= '0;
      bc_va    <= '0;
      bc_exp   <= '0;
    end else begin
      done   <= 1'b0;
      fault  <= 1'b0;
      bc_vld <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pg_req) begin
            if (rq_bad) fault <= 1'b1;
            else begin
              st       <= S_SCAN;
              idx      <= '0;
              bc_vld   <= 1'b1;
              bc_remap <= pg_remap;
              bc_rid   <= rq_rid;
              bc_va    <= rq_va;
              bc_exp   <= rq_exp;
            end
          end else if (ins_ok) begin
            v[ins_idx] <= 1'b1;
          end
        end
        S_SCAN: begin
          if (hit_scan) v[idx] <= 1'b0;
          if (idx == LAST) st <= S_WAIT;
          idx <= idx + 1'b1;
        end
        default: begin
          if (drained) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R9
  done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(drained) && !busy && $past(st == S_WAIT)));

  // R5
  fault_keeps_entries_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ((v == $past(v)) && !bc_vld && !busy));

  // R8
  notice_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_vld |-> (busy && !$past(busy)));

  // R7
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bc_vld);

  // R4
  clear_only_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(v) & ~v)) |-> $past(st == S_SCAN));

  // R6
  bad_size_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && idle && (rq_exp > EPUMAX)) |=> fault);
endmodule

// File: tb/sim_tlb_range_purge.sv
`timescale 1ns/1ps
module sim_tlb_range_purge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_en = 0; logic [2:0] ins_idx = 0, ins_rid = 0; logic [60:0] ins_va = 0; logic [5:0] ins_exp = 0;
  logic [2:0] lk_rid = 0; logic [60:0] lk_va = 0; logic lk_hit;
  logic pg_req = 0; logic [63:0] pg_addr = 0, pg_size = 0; logic pg_remap = 0;
  logic [1:0] cpl = 0; logic vm = 0; logic drained = 1;
  logic busy, done, fault, bc_vld, bc_remap; logic [2:0] bc_rid; logic [60:0] bc_va; logic [5:0] bc_exp;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  tlb_range_purge u0 (.clk, .rst_n, .ins_en, .ins_idx, .ins_rid, .ins_va, .ins_exp,
    .lk_rid, .lk_va, .lk_hit, .pg_req, .pg_addr, .pg_size, .pg_remap, .cpl, .vm, .drained,
    .busy, .done, .fault, .bc_vld, .bc_remap, .bc_rid, .bc_va, .bc_exp);

  // entry set: {rid, va, exp}; pairwise disjoint within a region
  localparam logic [69:0] ENT [0:7] = '{
    {3'd1, 61'h0000_1000, 6'd12}, {3'd1, 61'h0010_0000, 6'd20},
    {3'd1, 61'h0040_0000, 6'd22}, {3'd2, 61'h0000_1000, 6'd12},
    {3'd1, 61'h1000_0000, 6'd28}, {3'd1, 61'h0000_3000, 6'd12},
    {3'd7, 61'h1FFF_FFFF_FFFF_F000, 6'd12}, {3'd1, 61'h0080_0000, 6'd14}};

  // purge vectors: {rid, va, exp, remap, expected fault}
  localparam logic [71:0] VEC [0:10] = '{
    {3'd1, 61'h0000_1000, 6'd12, 1'b0, 1'b0},   // exact page
    {3'd1, 61'h0000_0000, 6'd14, 1'b0, 1'b0},   // window covers two pages
    {3'd1, 61'h0050_0123, 6'd12, 1'b0, 1'b0},   // unaligned, inside large page
    {3'd1, 61'h0000_0000, 6'd24, 1'b1, 1'b0},   // wide window
    {3'd2, 61'h0000_1000, 6'd12, 1'b0, 1'b0},   // other region only
    {3'd3, 61'h0000_0000, 6'd60, 1'b0, 1'b0},   // empty region, largest size
    {3'd7, 61'h1FFF_FFFF_FFFF_F000, 6'd12, 1'b1, 1'b0}, // top of space
    {3'd1, 61'h0000_0000, 6'd11, 1'b0, 1'b1},   // size too small
    {3'd1, 61'h0000_0000, 6'd61, 1'b0, 1'b1},   // size too large
    {3'd1, 61'h1000_0000, 6'd16, 1'b1, 1'b0},   // window inside 256M page
    {3'd1, 61'h0000_2000, 6'd12, 1'b0, 1'b0}};  // gap, no match

  logic [7:0] ref_v;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit ovl(input logic [60:0] a, input int ea, input logic [60:0] b, input int eb);
    logic [63:0] as, ae, bs, be;
    as = {3'b0, a} & ~((64'd1 << ea) - 64'd1); ae = as + (64'd1 << ea);
    bs = {3'b0, b} & ~((64'd1 << eb) - 64'd1); be = bs + (64'd1 << eb);
    return !(ae <= bs) && !(be <= as);
  endfunction

  task automatic ins(input int i, input logic [2:0] r, input logic [60:0] a, input logic [5:0] e);
    @(negedge clk); ins_en = 1; ins_idx = 3'(i); ins_rid = r; ins_va = a; ins_exp = e;
    @(negedge clk); ins_en = 0;
  endtask

  task automatic load_all;
    for (int i = 0; i < 8; i++) ins(i, ENT[i][69:67], ENT[i][66:6], ENT[i][5:0]);
    ref_v = 8'hFF;
  endtask

  task automatic look(input logic [2:0] r, input logic [60:0] a, output logic h);
    lk_rid = r; lk_va = a; #0.5; h = lk_hit;
  endtask

  task automatic check_entries(input string req);
    logic h;
    for (int i = 0; i < 8; i++) begin
      look(ENT[i][69:67], ENT[i][66:6], h);
      chk(h == ref_v[i], req, {63'd0, h}, {63'd0, ref_v[i]});
    end
  endtask

  task automatic issue(input logic [2:0] r, input logic [60:0] a, input logic [5:0] e, input bit rm);
    @(negedge clk); pg_req = 1; pg_addr = {r, a}; pg_size = {56'd0, e, 2'b01}; pg_remap = rm;
    @(negedge clk); pg_req = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (done) seen = 1; else @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic h; bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !fault && !bc_vld, "R11 outputs idle after reset", {busy, done, fault, bc_vld}, 0);
    ref_v = 8'h00; check_entries("R11 empty after reset");
    load_all;
    check_entries("R10 loaded entries hit");
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    ref_v = 8'h00; check_entries("R11 reset clears entries");

    // vector table walk
    for (int j = 0; j < 11; j++) begin
      logic [2:0] r; logic [60:0] a; logic [5:0] e; bit rm, ef;
      {r, a, e, rm, ef} = VEC[j];
      load_all;
      issue(r, a, e, rm);
      chk(fault == ef, "R6 fault vs size range", {63'd0, fault}, {63'd0, ef});
      chk(bc_vld == !ef, "R8 notice pulse on accept", {63'd0, bc_vld}, {63'd0, !ef});
      if (!ef) begin
        chk({bc_remap, bc_rid, bc_va, bc_exp} == {rm, r, a, e}, "R8 notice fields",
            {bc_remap, bc_rid, bc_va[53:0], bc_exp}, {rm, r, a[53:0], e});
        chk(busy, "R8 busy after accept", {63'd0, busy}, 1);
        wait_done(seen);
        chk(seen && !busy, "R9 done pulse with busy low", {62'd0, seen, busy}, 2);
        @(negedge clk);
        chk(!done, "R9 done lasts one cycle", {63'd0, done}, 0);
        for (int i = 0; i < 8; i++)
          if (ENT[i][69:67] == r && ovl(ENT[i][66:6], int'(ENT[i][5:0]), a, int'(e))) ref_v[i] = 1'b0;
      end
      check_entries("R1 R2 R3 R4 entry state after purge");
    end

    // R5 privilege and mode faults
    load_all;
    cpl = 2'd1; issue(3'd1, 61'h0, 6'd30, 0);
    chk(fault && !bc_vld && !busy, "R5 privilege fault", {fault, bc_vld, busy}, 4);
    @(negedge clk);
    chk(!fault, "R5 fault lasts one cycle", {63'd0, fault}, 0);
    cpl = 2'd0; vm = 1; issue(3'd1, 61'h0, 6'd30, 0);
    chk(fault && !bc_vld, "R5 vm fault", {fault, bc_vld}, 2);
    vm = 0; check_entries("R5 entries unchanged after fault");

    // R7 and R9 drain hold and single in flight
    drained = 0;
    issue(3'd1, 61'h0000_1000, 6'd12, 0);
    repeat (3) @(negedge clk);
    issue(3'd2, 61'h0000_1000, 6'd12, 0);
    ins(0, 3'd4, 61'h0200_0000, 6'd12);
    repeat (20) @(negedge clk);
    chk(busy && !done, "R9 held busy while not drained", {busy, done}, 2);
    drained = 1;
    wait_done(seen);
    chk(seen, "R9 completes after drain", {63'd0, seen}, 1);
    ref_v[0] = 1'b0; check_entries("R7 second request ignored");
    look(3'd4, 61'h0200_0000, h);
    chk(!h, "R10 insert while busy ignored", {63'd0, h}, 0);

    // R10 insert size limits
    ins(0, 3'd5, 61'h0300_0000, 6'd29);
    look(3'd5, 61'h0300_0000, h);
    chk(!h, "R10 exponent 29 ignored", {63'd0, h}, 0);
    ins(0, 3'd5, 61'h0300_0000, 6'd11);
    look(3'd5, 61'h0300_0000, h);
    chk(!h, "R10 exponent 11 ignored", {63'd0, h}, 0);
    ins(0, 3'd5, 61'h0300_0000, 6'd28);
    look(3'd5, 61'h0FFF_FFFF, h);
    chk(h, "R10 exponent 28 covers page end", {63'd0, h}, 1);
    look(3'd5, 61'h1000_0000, h);
    chk(!h, "R10 miss past page end", {63'd0, h}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule